// File: doc/BRIEF.md
# Concatenable Multi-Channel PWM Generator

The block drives eight pulse-width-modulated pins. Each channel has an 8-bit counter, a period register, a duty register, a polarity bit, an alignment bit and an enable bit. An edge-aligned channel counts upward and wraps. A center-aligned channel counts up and then back down, so its pulse sits symmetrically inside a window twice as long.

A neighbouring pair of channels can be joined into one 16-bit channel for finer resolution. The pairs are (1,0), (3,2), (5,4) and (7,6). In a joined pair:
- the odd (higher) channel's period and duty registers supply the upper byte;
- the even channel's registers supply the lower byte;
- the odd channel's enable, polarity and alignment bits govern the pair;
- the odd pin carries the waveform.

Any mix of joined and single pairs is allowed. The counters advance only on cycles where the tick input is high, so a divider placed outside the block can set the count rate.

Software writes one byte per cycle through a plain write port. Period and duty writes go to pending registers. A running channel copies them into its working registers only at the end of its current period. A disabled channel copies them continuously, so the values written before enabling are the ones the channel starts with.

Top module: `pwm_bank`

## Requirements
- R1: An edge-aligned channel with period P repeats every P ticks; P=0 behaves as P=1. Its counter runs 0..P-1 from zero at enable, and the channel is active while the counter is below the duty value D.
- R2: A duty of 0 gives a constant inactive level. A duty of at least the period gives a constant active level. Both hold in either alignment, with no pulse at all.
- R3: A center-aligned channel repeats every 2P ticks. Its counter goes 0,1..P-1, holds P-1 for one more tick, counts down to 0, and holds 0 for one more tick. The channel is active while counter + D >= P, which gives a pulse of 2·min(D,P) ticks centered in the window.
- R4: Pin level = polarity bit XOR active. A polarity bit of 0 means active-high and idle-low; a polarity bit of 1 inverts this.
- R5: A disabled channel holds its counter at zero and drives its pin at the inactive level, which equals its polarity bit. On enabling, the count restarts from zero.
- R6: When join bit k is set, channels 2k+1 and 2k form one 16-bit channel.
  - Period is {period[2k+1], period[2k]} and duty is {duty[2k+1], duty[2k]}.
  - Pin 2k+1 carries the waveform under channel 2k+1's enable, polarity and alignment bits.
  - Pin 2k stays at its own polarity bit.
  - Other pairs run independently.
- R7: While a channel is enabled, a write to its period or duty register takes effect only from the start of its next period.
- R8: Counters advance only on cycles with tick high. While tick is low, every pin holds its level.
- R9: Register write map, one byte per cycle while the write enable is high:
  - address n (0..7) is the period of channel n;
  - address 8+n is the duty of channel n;
  - address 16 is the enable mask (bit n = channel n);
  - address 17 is the polarity mask;
  - address 18 is the center-align mask;
  - address 19 bits 0..3 are the join mask (bit k joins channels 2k+1 and 2k).
- R10: After reset every register is zero and every pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for all counters |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address (map in R9) |
| wrData | input | 8 | Register write data |
| pwmOut | output | 8 | PWM pins, bit n = channel n |

## Verification
The assertions on counter bounds, on counter freezing while tick is low, and on a joined pair's pins assume two things:
- a pair's join bit changes only while both of its channels are disabled;
- the alignment bit of a running channel is not changed.

The stimulus meets both. Join and alignment masks are written only after the enable mask has cleared the affected channels, and every waveform run starts from a fresh enable. Period and duty, by contrast, are rewritten mid-period on purpose, to exercise the end-of-period update.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Mode bits handed from the register file to one channel pair.
  typedef struct packed {
    logic enLo;
    logic enHi;
    logic invLo;
    logic invHi;
    logic cenLo;
    logic cenHi;
    logic joined;
  } pairCfgT;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile #(
  parameter int CH = 8,
  parameter int CW = 8,
  parameter int AW = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [AW-1:0]                  wrAddr,
  input  logic [CW-1:0]                  wrData,
  output logic [CH-1:0][CW-1:0]          perPend,
  output logic [CH-1:0][CW-1:0]          dutyPend,
  output pwm_pkg::pairCfgT [CH/2-1:0]    cfg
);
  localparam int PAIRS     = CH / 2;
  localparam int ADDR_EN   = 2 * CH;
  localparam int ADDR_INV  = 2 * CH + 1;
  localparam int ADDR_CEN  = 2 * CH + 2;
  localparam int ADDR_JOIN = 2 * CH + 3;

  logic [CH-1:0]    enMask, invMask, cenMask;
  logic [PAIRS-1:0] joinMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perPend  <= '0;
      dutyPend <= '0;
      enMask   <= '0;
      invMask  <= '0;
      cenMask  <= '0;
      joinMask <= '0;
    end else if (wrEn) begin
      for (int n = 0; n < CH; n++) begin
        if (wrAddr == AW'(n))      perPend[n]  <= wrData;
        if (wrAddr == AW'(CH + n)) dutyPend[n] <= wrData;
      end
      if (wrAddr == AW'(ADDR_EN))   enMask   <= wrData[CH-1:0];
      if (wrAddr == AW'(ADDR_INV))  invMask  <= wrData[CH-1:0];
      if (wrAddr == AW'(ADDR_CEN))  cenMask  <= wrData[CH-1:0];
      if (wrAddr == AW'(ADDR_JOIN)) joinMask <= wrData[PAIRS-1:0];
    end
  end

  always_comb begin
    for (int k = 0; k < PAIRS; k++) begin
      cfg[k].enLo   = enMask[2*k];
      cfg[k].enHi   = enMask[2*k+1];
      cfg[k].invLo  = invMask[2*k];
      cfg[k].invHi  = invMask[2*k+1];
      cfg[k].cenLo  = cenMask[2*k];
      cfg[k].cenHi  = cenMask[2*k+1];
      cfg[k].joined = joinMask[k];
    end
  end

  // R9: an enable-mask write is visible on the next cycle
  assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == AW'(ADDR_EN)) |=> (enMask == $past(wrData[CH-1:0])));

  // R9: a join-mask write is visible on the next cycle
  assert_join_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == AW'(ADDR_JOIN)) |=> (joinMask == $past(wrData[PAIRS-1:0])));

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  pwm_pkg::pairCfgT cfg,
  input  logic [CW-1:0]    perPendLo,
  input  logic [CW-1:0]    perPendHi,
  input  logic [CW-1:0]    dutyPendLo,
  input  logic [CW-1:0]    dutyPendHi,
  output logic             pinLo,
  output logic             pinHi
);
  localparam int DW = 2 * CW;

  typedef struct packed {
    logic [DW-1:0] cnt;
    logic          down;
    logic          wrap;
  } stepT;

  function automatic stepT advance(input logic [DW-1:0] cnt, input logic [DW-1:0] per,
                                   input logic down, input logic cen);
    logic [DW-1:0] last;
    stepT s;
    last   = (per == '0) ? '0 : per - DW'(1);
    s.cnt  = cnt;
    s.down = 1'b0;
    s.wrap = 1'b0;
    if (!cen) begin
      if (cnt >= last) begin s.cnt = '0; s.wrap = 1'b1; end
      else s.cnt = cnt + DW'(1);
    end else if (!down) begin
      if (cnt >= last) s.down = 1'b1;
      else s.cnt = cnt + DW'(1);
    end else begin
      s.down = 1'b1;
      if (cnt == '0) begin s.down = 1'b0; s.wrap = 1'b1; end
      else s.cnt = cnt - DW'(1);
    end
    return s;
  endfunction

  function automatic logic isActive(input logic [DW-1:0] cnt, input logic [DW-1:0] per,
                                    input logic [DW-1:0] duty, input logic cen);
    logic [DW-1:0] perEff;
    perEff = (per == '0) ? DW'(1) : per;
    if (cen) return ({1'b0, cnt} + {1'b0, duty}) >= {1'b0, perEff};
    return cnt < duty;
  endfunction

  logic [CW-1:0] cntLo, cntHi, perLo, perHi, dutyLo, dutyHi;
  logic          downLo, downHi;

  logic [DW-1:0] hCnt, hPer, hDuty, hLast, hNext;
  logic [DW-1:0] lCnt, lPer, lDuty, lLast, lNext;
  logic          hDownN, lDownN, lEn, hLoad, loLoad, actHi, actLo;
  stepT          hStep, lStep;

  always_comb begin
    hCnt  = cfg.joined ? {cntHi, cntLo}   : DW'(cntHi);
    hPer  = cfg.joined ? {perHi, perLo}   : DW'(perHi);
    hDuty = cfg.joined ? {dutyHi, dutyLo} : DW'(dutyHi);
    lCnt  = DW'(cntLo);
    lPer  = DW'(perLo);
    lDuty = DW'(dutyLo);
    hLast = (hPer == '0) ? '0 : hPer - DW'(1);
    lLast = (lPer == '0) ? '0 : lPer - DW'(1);
    lEn   = cfg.enLo & ~cfg.joined;

    hStep = advance(hCnt, hPer, downHi, cfg.cenHi);
    lStep = advance(lCnt, lPer, downLo, cfg.cenLo);

    hNext  = hCnt;
    hDownN = downHi;
    if (!cfg.enHi) begin hNext = '0; hDownN = 1'b0; end
    else if (tick) begin hNext = hStep.cnt; hDownN = hStep.down; end

    lNext  = lCnt;
    lDownN = downLo;
    if (!lEn) begin lNext = '0; lDownN = 1'b0; end
    else if (tick) begin lNext = lStep.cnt; lDownN = lStep.down; end

    hLoad  = !cfg.enHi || (tick && hStep.wrap);
    loLoad = cfg.joined ? hLoad : (!lEn || (tick && lStep.wrap));

    actHi = isActive(hCnt, hPer, hDuty, cfg.cenHi);
    actLo = isActive(lCnt, lPer, lDuty, cfg.cenLo);
    pinHi = cfg.invHi ^ (cfg.enHi & actHi);
    pinLo = cfg.invLo ^ (lEn & actLo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0; cntHi <= '0; downLo <= 1'b0; downHi <= 1'b0;
      perLo <= '0; perHi <= '0; dutyLo <= '0; dutyHi <= '0;
    end else begin
      cntHi  <= cfg.joined ? hNext[DW-1:CW] : hNext[CW-1:0];
      cntLo  <= cfg.joined ? hNext[CW-1:0]  : lNext[CW-1:0];
      downHi <= hDownN;
      downLo <= lDownN;
      if (hLoad)  begin perHi <= perPendHi; dutyHi <= dutyPendHi; end
      if (loLoad) begin perLo <= perPendLo; dutyLo <= dutyPendLo; end
    end
  end

  // R5: a disabled channel has a zero counter on the following cycle
  assert_disabled_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enHi |=> (cntHi == '0));

  // R1: a running single channel never counts past its last state (R3 shares the bound)
  assert_lo_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    lEn |-> (lCnt <= lLast));

  // R3: the high (or joined) lane stays within its period
  assert_hi_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfg.enHi |-> (hCnt <= hLast));

  // R7: working duty and period hold until a period ends
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enHi && !(tick && hStep.wrap)) |=> ($stable(dutyHi) && $stable(perHi)));

  // R8: no count movement without a tick
  assert_tick_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enHi && !tick) |=> $stable(cntHi));

  // R6: a joined pair's low pin sits at its idle level
  assert_joined_low_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfg.joined |-> (pinLo == cfg.invLo));

  // R2: zero duty never produces an active level
  assert_zero_duty_flat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enHi && hDuty == '0) |-> (pinHi == cfg.invHi));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int CHANNELS = 8,
  parameter int CNT_W    = 8,
  localparam int ADDR_W  = $clog2(2 * CHANNELS + 4)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  output logic [CHANNELS-1:0] pwmOut
);
  localparam int PAIRS = CHANNELS / 2;

  logic [CHANNELS-1:0][CNT_W-1:0] perPend, dutyPend;
  pwm_pkg::pairCfgT [PAIRS-1:0]   cfgBus;

  pwm_regfile #(.CH(CHANNELS), .CW(CNT_W), .AW(ADDR_W)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .perPend(perPend), .dutyPend(dutyPend), .cfg(cfgBus)
  );

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    pwm_pair #(.CW(CNT_W)) i_pair (
      .clk(clk), .rstN(rstN), .tick(tick), .cfg(cfgBus[k]),
      .perPendLo(perPend[2*k]),   .perPendHi(perPend[2*k+1]),
      .dutyPendLo(dutyPend[2*k]), .dutyPendHi(dutyPend[2*k+1]),
      .pinLo(pwmOut[2*k]), .pinHi(pwmOut[2*k+1])
    );
  end

endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b1, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [7:0]    pwmOut;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] enM = '0, invM = '0, cenM = '0, joinM = '0;

  pwm_bank i_pwm_bank (.clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
                       .wrAddr(wrAddr), .wrData(wrData), .pwmOut(pwmOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input int a, input int d);
    wrAddr = AW'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic expPin(input int k, input int p, input int d, input bit cen, input bit inv);
    int pe, m, c;
    bit a;
    pe = (p == 0) ? 1 : p;
    if (!cen) a = (k % pe) < d;
    else begin
      m = k % (2 * pe);
      c = (m < pe) ? m : 2 * pe - 1 - m;
      a = (c + d) >= pe;
    end
    return inv ^ a;
  endfunction

  task automatic sweep8(input int ch, input int p, input int d, input bit cen, input bit inv);
    string tag;
    int pe, len;
    pe  = (p == 0) ? 1 : p;
    tag = cen ? "R3" : "R1";
    if (d == 0 || d >= pe) tag = {tag, "/R2"};
    if (inv) tag = {tag, "/R4"};
    wr(ch, p); wr(8 + ch, d);
    cenM[ch] = cen; wr(18, cenM);
    invM[ch] = inv; wr(17, invM);
    chk(pwmOut[ch], inv, "R5 idle level before enable");
    enM[ch] = 1'b1; wr(16, enM);
    len = cen ? 4 * pe + 2 : 2 * pe + 2;
    for (int k = 0; k < len; k++) begin
      chk(pwmOut[ch], expPin(k, p, d, cen, inv), tag);
      @(negedge clk);
    end
    enM[ch] = 1'b0; wr(16, enM);
    chk(pwmOut[ch], inv, "R5 inactive after disable");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pwmOut[0], 1'b0, "R10 pin0 in reset");
    rstN = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 8; n++) chk(pwmOut[n], 1'b0, "R10 reset level");

    // R1 R2 R3 R4: sweep period, duty, alignment and polarity on channel 1
    for (int cen = 0; cen < 2; cen++)
      for (int p = 0; p <= 5; p++)
        for (int d = 0; d <= p + 1; d++)
          sweep8(1, p, d, cen[0], ((p + d) % 2) == 1);
    invM = '0; cenM = '0; wr(17, invM); wr(18, cenM);

    // R7: duty rewritten mid-period takes effect at the next period
    begin
      logic exp7 [8] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      wr(2, 4); wr(10, 1);
      enM[2] = 1'b1; wr(16, enM);
      chk(pwmOut[2], exp7[0], "R7 first cycle");
      wr(10, 3);
      for (int k = 1; k < 8; k++) begin
        chk(pwmOut[2], exp7[k], "R7 deferred duty");
        @(negedge clk);
      end
      enM[2] = 1'b0; wr(16, enM);
    end

    // R8: counters freeze while tick is low
    wr(3, 4); wr(11, 1);
    enM[3] = 1'b1; wr(16, enM);
    tick = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(pwmOut[3], 1'b1, "R8 frozen without tick");
      @(negedge clk);
    end
    tick = 1'b1;
    @(negedge clk);
    for (int k = 1; k < 6; k++) begin
      chk(pwmOut[3], expPin(k, 4, 1, 1'b0, 1'b0), "R8 resumes with tick");
      @(negedge clk);
    end
    enM[3] = 1'b0; wr(16, enM);

    // R5: disabling clears the count, re-enabling restarts from zero
    wr(0, 5); wr(8, 2);
    enM[0] = 1'b1; wr(16, enM);
    @(negedge clk); @(negedge clk); @(negedge clk);
    enM[0] = 1'b0; wr(16, enM);
    chk(pwmOut[0], 1'b0, "R5 disabled pin low");
    @(negedge clk);
    enM[0] = 1'b1; wr(16, enM);
    for (int k = 0; k < 10; k++) begin
      chk(pwmOut[0], expPin(k, 5, 2, 1'b0, 1'b0), "R5 restart from zero");
      @(negedge clk);
    end
    enM[0] = 1'b0; wr(16, enM);

    // R6: channels 7:6 joined (period 300, duty 100) beside single channel 0
    joinM = 8'b1000; wr(19, joinM);
    wr(7, 1); wr(6, 44); wr(15, 0); wr(14, 100);
    wr(0, 7); wr(8, 3);
    invM = 8'b0100_0000; wr(17, invM);
    chk(pwmOut[6], 1'b1, "R4 idle level follows polarity");
    for (int cen = 0; cen < 2; cen++) begin
      cenM[7] = cen[0]; wr(18, cenM);
      enM = 8'b1100_0001; wr(16, enM);
      for (int k = 0; k < (cen != 0 ? 1250 : 650); k++) begin
        chk(pwmOut[7], expPin(k, 300, 100, cen[0], 1'b0), "R6 joined waveform");
        chk(pwmOut[6], 1'b1, "R6 joined low pin idle");
        chk(pwmOut[0], expPin(k, 7, 3, 1'b0, 1'b0), "R6 other pair independent");
        @(negedge clk);
      end
      enM = '0; wr(16, enM);
    end
    joinM = '0; wr(19, joinM);
    cenM = '0; wr(18, cenM);
    invM = '0; wr(17, invM);
    for (int n = 0; n < 8; n++) chk(pwmOut[n], 1'b0, "R5 all disabled");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule